// File: doc/BRIEF.md
# Branch Target Buffer Fetch Predictor

This block chooses the next fetch address for a 32-bit pipeline with fixed 4-byte instructions. Every cycle the fetch stage presents the current instruction address together with a few fields the predecoder has already pulled out of the fetched word: a branch flag, a jump flag, the 26-bit absolute jump field and the 16-bit signed branch offset. A small fully associative table of recently seen control-flow instructions is searched with no clock delay. The block returns the predicted next address, a taken flag, and a hit flag with that entry's use count.

When a branch or jump is not found in the table, it is entered on the next clock edge. The entry is keyed by its own address, starts with an undecided prediction, and stores a target computed from the predecoded fields. A separate resolve port is driven once the real outcome of a branch is known, and it records taken or not-taken in the matching entry. An undecided entry predicts not-taken until a resolve writes to it. All state updates happen on the clock edge. Only the valid bits and the replacement pointer are reset.

Top module: `btb_fetch_predictor`

## Requirements
- R1: If the lookup address matches a valid entry whose state is taken (code 2'b10), `nxt_pc` equals that entry's stored target and `pred_taken` is 1, in the same cycle.
- R2: If the lookup matches an entry whose state is undecided (2'b00) or not-taken (2'b01), `nxt_pc` is `lk_pc + 4`, `pred_taken` is 0 and `lk_hit` is 1.
- R3: If the lookup matches no valid entry, `lk_hit` is 0, `pred_taken` is 0, `lk_hit_count` is 0 and `nxt_pc` is `lk_pc + 4`. This includes the cycle in which the missing instruction is being allocated.
- R4: If a miss occurs with `lk_is_branch` or `lk_is_jump` set, an entry is written at the next edge, keyed by `lk_pc`, with state undecided. Later lookups of that address then hit and predict not-taken.
- R5: The target of a jump entry is `lk_jump_field` shifted left by two and zero-extended. No upper address bits are merged in. If both flags are set, the jump form is used.
- R6: The target of a branch entry is `lk_pc + 4 + (sign-extended lk_imm << 2)`.
- R7: The use count of a new entry is 1. It rises by 1 at every edge at which a lookup hits that entry, and it saturates at its maximum value. `lk_hit_count` shows the stored count of the hit entry before that cycle's increment.
- R8: Allocation happens only on a miss, so no address is ever held by more than one valid entry.
- R9: An allocation uses the lowest-numbered invalid entry. When every entry is valid, it replaces the entry under a replacement pointer, and the pointer then steps by one, modulo the entry count.
- R10: A resolve with `rs_valid` set writes taken (`rs_taken`=1) or not-taken into the entry matching `rs_pc` at the next edge. A resolve with no matching entry changes nothing. If an allocation replaces the same entry in the same cycle, the allocation wins.
- R11: A synchronous active-high `rst` invalidates every entry and returns the replacement pointer to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | 32 | Address of the instruction being fetched |
| lk_is_branch | input | 1 | Predecoded: instruction is a PC-relative branch |
| lk_is_jump | input | 1 | Predecoded: instruction is an absolute jump |
| lk_jump_field | input | 26 | Predecoded jump field (word address) |
| lk_imm | input | 16 | Predecoded signed branch offset in words |
| nxt_pc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Prediction: 1 taken, 0 not taken |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_hit_count | output | 16 | Use count of the matched entry, 0 on a miss |
| rs_valid | input | 1 | Resolve request |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Resolved outcome |

## Verification
The lookup outputs (`nxt_pc`, `pred_taken`, `lk_hit`, `lk_hit_count`) are combinational and are due in the cycle the address is presented. The bench drives inputs on the falling edge and samples one nanosecond later, well before the next rising edge. Allocation, count increments, resolve writes and reset take effect at the next rising edge, so they first show up at the lookup one cycle later. The bench's reference model updates its own table only after that rising edge, so every expected value comes from the state the design held before the edge.

// File: rtl/btbp_pkg.sv
package btbp_pkg;

   typedef enum logic [1:0] {
      PST_UNSET     = 2'b00,
      PST_NOT_TAKEN = 2'b01,
      PST_TAKEN     = 2'b10
   } pred_state_e;

endpackage

// File: rtl/btbp_match.sv
module btbp_match #(
   parameter int NUM = 8,
   parameter int AW  = 32,
   localparam int IW = $clog2(NUM)
) (
   input  logic [NUM-1:0]         vld,
   input  logic [NUM-1:0][AW-1:0] tags,
   input  logic [AW-1:0]          key,
   output logic [NUM-1:0]         hit_vec,
   output logic                   hit,
   output logic [IW-1:0]          idx
);

   for (genvar g = 0; g < NUM; g++) begin : g_cmp
      assign hit_vec[g] = vld[g] && (tags[g] == key);
   end

   assign hit = |hit_vec;

   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM; i++) begin
         if (hit_vec[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/btbp_target_calc.sv
module btbp_target_calc #(
   parameter int AW    = 32,
   parameter int JW    = 26,
   parameter int IMMW  = 16
) (
   input  logic [AW-1:0]   pc,
   input  logic            is_jump,
   input  logic [JW-1:0]   jfield,
   input  logic [IMMW-1:0] imm,
   output logic [AW-1:0]   target
);

   localparam int EXT_W = AW - IMMW - 2;

   if (EXT_W < 1) begin : g_bad_width
      $error("btbp_target_calc: address width too small for offset");
   end

   logic [AW-1:0] jmp_tgt;
   logic [AW-1:0] br_off;
   logic [AW-1:0] br_tgt;

   assign jmp_tgt = AW'({jfield, 2'b00});
   assign br_off  = {{EXT_W{imm[IMMW-1]}}, imm, 2'b00};
   assign br_tgt  = pc + AW'(4) + br_off;
   assign target  = is_jump ? jmp_tgt : br_tgt;

endmodule

// File: rtl/btbp_victim.sv
module btbp_victim #(
   parameter int NUM = 8,
   localparam int IW = $clog2(NUM)
) (
   input  logic [NUM-1:0] vld,
   input  logic [IW-1:0]  rr_ptr,
   output logic [IW-1:0]  slot,
   output logic           full
);

   assign full = &vld;

   always_comb begin
      slot = rr_ptr;
      for (int i = NUM - 1; i >= 0; i--) begin
         if (!vld[i]) slot = IW'(i);
      end
   end

endmodule

// File: rtl/btb_fetch_predictor.sv
module btb_fetch_predictor #(
   parameter int NUM_ENTRIES = 8,
   parameter int ADDR_W      = 32,
   parameter int JFIELD_W    = 26,
   parameter int IMM_W       = 16,
   parameter int CNT_W       = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [ADDR_W-1:0]   lk_pc,
   input  logic                lk_is_branch,
   input  logic                lk_is_jump,
   input  logic [JFIELD_W-1:0] lk_jump_field,
   input  logic [IMM_W-1:0]    lk_imm,
   output logic [ADDR_W-1:0]   nxt_pc,
   output logic                pred_taken,
   output logic                lk_hit,
   output logic [CNT_W-1:0]    lk_hit_count,
   input  logic                rs_valid,
   input  logic [ADDR_W-1:0]   rs_pc,
   input  logic                rs_taken
);
   import btbp_pkg::*;

   localparam int          IW      = $clog2(NUM_ENTRIES);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [IW-1:0]    RR_LAST = IW'(NUM_ENTRIES - 1);

   if (NUM_ENTRIES < 2) begin : g_bad_depth
      $error("btb_fetch_predictor: need at least two entries");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("btb_fetch_predictor: counter width below 2");
   end

   logic [NUM_ENTRIES-1:0]             vld_q;
   logic [NUM_ENTRIES-1:0][ADDR_W-1:0] tag_q;
   logic [NUM_ENTRIES-1:0][ADDR_W-1:0] tgt_q;
   pred_state_e                        st_q  [NUM_ENTRIES];
   logic [CNT_W-1:0]                   cnt_q [NUM_ENTRIES];
   logic [IW-1:0]                      rr_q;

   logic [NUM_ENTRIES-1:0] lk_hit_vec;
   logic [IW-1:0]          lk_idx;
   logic [NUM_ENTRIES-1:0] rs_hit_vec;
   logic                   rs_hit;
   logic [IW-1:0]          rs_idx;
   logic [IW-1:0]          vic_slot;
   logic                   tbl_full;
   logic [ADDR_W-1:0]      new_tgt;
   logic                   alloc;
   logic                   hit_taken;

   btbp_match #(.NUM(NUM_ENTRIES), .AW(ADDR_W)) u_lk_match (
      .vld     (vld_q),
      .tags    (tag_q),
      .key     (lk_pc),
      .hit_vec (lk_hit_vec),
      .hit     (lk_hit),
      .idx     (lk_idx)
   );

   btbp_match #(.NUM(NUM_ENTRIES), .AW(ADDR_W)) u_rs_match (
      .vld     (vld_q),
      .tags    (tag_q),
      .key     (rs_pc),
      .hit_vec (rs_hit_vec),
      .hit     (rs_hit),
      .idx     (rs_idx)
   );

   btbp_victim #(.NUM(NUM_ENTRIES)) u_victim (
      .vld    (vld_q),
      .rr_ptr (rr_q),
      .slot   (vic_slot),
      .full   (tbl_full)
   );

   btbp_target_calc #(.AW(ADDR_W), .JW(JFIELD_W), .IMMW(IMM_W)) u_tgt (
      .pc      (lk_pc),
      .is_jump (lk_is_jump),
      .jfield  (lk_jump_field),
      .imm     (lk_imm),
      .target  (new_tgt)
   );

   assign alloc        = !lk_hit && (lk_is_branch || lk_is_jump);
   assign hit_taken    = lk_hit && (st_q[lk_idx] == PST_TAKEN);
   assign pred_taken   = hit_taken;
   assign nxt_pc       = hit_taken ? tgt_q[lk_idx] : lk_pc + ADDR_W'(4);
   assign lk_hit_count = lk_hit ? cnt_q[lk_idx] : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= '0;
         rr_q  <= '0;
      end else begin
         for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (alloc && vic_slot == IW'(i)) begin
               vld_q[i] <= 1'b1;
               tag_q[i] <= lk_pc;
               tgt_q[i] <= new_tgt;
               st_q[i]  <= PST_UNSET;
               cnt_q[i] <= CNT_W'(1);
            end else begin
               if (lk_hit && lk_idx == IW'(i) && cnt_q[i] != CNT_MAX)
                  cnt_q[i] <= cnt_q[i] + CNT_W'(1);
               if (rs_valid && rs_hit && rs_idx == IW'(i))
                  st_q[i] <= rs_taken ? PST_TAKEN : PST_NOT_TAKEN;
            end
         end
         if (alloc && tbl_full)
            rr_q <= (rr_q == RR_LAST) ? '0 : rr_q + IW'(1);
      end
   end

endmodule

// File: rtl/btb_fetch_predictor_chk.sv
module btb_fetch_predictor_chk #(
   parameter int N  = 8,
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst,
   input logic [AW-1:0] lk_pc,
   input logic          lk_is_branch,
   input logic          lk_is_jump,
   input logic          lk_hit,
   input logic          pred_taken,
   input logic [AW-1:0] nxt_pc,
   input logic [N-1:0]  vld,
   input logic [N-1:0]  hit_vec
);

   logic miss_alloc;
   assign miss_alloc = !lk_hit && (lk_is_branch || lk_is_jump);

   AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
      pred_taken |-> lk_hit); // R1

   AST_SEQ_WHEN_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
      !pred_taken |-> (nxt_pc == lk_pc + AW'(4))); // R3

   AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit_vec)); // R8

   AST_ALLOC_FILLS_FREE: assert property (@(posedge clk) disable iff (rst)
      (miss_alloc && !(&vld)) |=> ($countones(vld) == $past($countones(vld)) + 1)); // R9

   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((vld & $past(vld)) == $past(vld))); // R11

endmodule

bind btb_fetch_predictor btb_fetch_predictor_chk #(
   .N  (NUM_ENTRIES),
   .AW (ADDR_W)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .lk_pc        (lk_pc),
   .lk_is_branch (lk_is_branch),
   .lk_is_jump   (lk_is_jump),
   .lk_hit       (lk_hit),
   .pred_taken   (pred_taken),
   .nxt_pc       (nxt_pc),
   .vld          (vld_q),
   .hit_vec      (lk_hit_vec)
);

// File: tb/btb_fetch_predictor_tb.sv
module btb_fetch_predictor_tb;

   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] lk_pc = '0;
   logic        lk_is_branch = 1'b0;
   logic        lk_is_jump = 1'b0;
   logic [25:0] lk_jump_field = '0;
   logic [15:0] lk_imm = '0;
   logic [31:0] nxt_pc;
   logic        pred_taken;
   logic        lk_hit;
   logic [15:0] lk_hit_count;
   logic        rs_valid = 1'b0;
   logic [31:0] rs_pc = '0;
   logic        rs_taken = 1'b0;

   always #4 clk = ~clk;

   btb_fetch_predictor u_dut (
      .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_is_branch(lk_is_branch),
      .lk_is_jump(lk_is_jump), .lk_jump_field(lk_jump_field), .lk_imm(lk_imm),
      .nxt_pc(nxt_pc), .pred_taken(pred_taken), .lk_hit(lk_hit),
      .lk_hit_count(lk_hit_count), .rs_valid(rs_valid), .rs_pc(rs_pc),
      .rs_taken(rs_taken)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   bit          m_vld [N];
   logic [31:0] m_tag [N];
   logic [31:0] m_tgt [N];
   logic [1:0]  m_st  [N];
   logic [15:0] m_cnt [N];
   int          m_rr;

   function automatic logic [31:0] ref_target(logic [31:0] pc, logic jp,
                                              logic [25:0] jf, logic [15:0] im);
      if (jp) return {4'b0000, jf, 2'b00};
      return pc + 32'd4 + {{14{im[15]}}, im, 2'b00};
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
      m_rr = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; lk_is_branch = 1'b0; lk_is_jump = 1'b0; rs_valid = 1'b0;
      @(posedge clk);
      model_clear();
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic do_cycle(input logic [31:0] pc, input logic br, input logic jp,
                           input logic [25:0] jf, input logic [15:0] im,
                           input logic rv, input logic [31:0] rpc, input logic rt,
                           input string tag);
      bit mh; int mi; bit rh; int ri; bit al; int slot;
      logic exp_pred; logic [31:0] exp_nxt; logic [15:0] exp_cnt;
      @(negedge clk);
      lk_pc = pc; lk_is_branch = br; lk_is_jump = jp; lk_jump_field = jf; lk_imm = im;
      rs_valid = rv; rs_pc = rpc; rs_taken = rt;
      #1;
      mh = 0; mi = 0; rh = 0; ri = 0;
      for (int i = 0; i < N; i++) begin
         if (m_vld[i] && m_tag[i] == pc)  begin mh = 1; mi = i; end
         if (m_vld[i] && m_tag[i] == rpc) begin rh = 1; ri = i; end
      end
      exp_pred = mh && m_st[mi] == 2'b10;
      exp_nxt  = exp_pred ? m_tgt[mi] : pc + 32'd4;
      exp_cnt  = mh ? m_cnt[mi] : 16'd0;
      check(tag, "hit R2/R3", {31'd0, lk_hit}, {31'd0, mh});
      check(tag, "pred R1/R2", {31'd0, pred_taken}, {31'd0, exp_pred});
      check(tag, "nxt_pc R1/R3", nxt_pc, exp_nxt);
      check(tag, "count R7", {16'd0, lk_hit_count}, {16'd0, exp_cnt});
      al = !mh && (br || jp);
      slot = -1;
      if (al) begin
         for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
         if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % N; end
      end
      @(posedge clk);
      if (mh && m_cnt[mi] != 16'hFFFF) m_cnt[mi] = m_cnt[mi] + 16'd1;
      if (rv && rh && ri != slot) m_st[ri] = rt ? 2'b10 : 2'b01;
      if (al) begin
         m_vld[slot] = 1'b1; m_tag[slot] = pc; m_tgt[slot] = ref_target(pc, jp, jf, im);
         m_st[slot] = 2'b00; m_cnt[slot] = 16'd1;
      end
   endtask

   task automatic idle_resolve(input logic [31:0] rpc, input logic rt, input string tag);
      do_cycle(32'hDEAD_0000, 1'b0, 1'b0, '0, '0, 1'b1, rpc, rt, tag);
   endtask

   logic [31:0] pool_pc  [16];
   logic        pool_br  [16];
   logic        pool_jp  [16];
   logic [25:0] pool_jf  [16];
   logic [15:0] pool_im  [16];

   localparam logic [31:0] PA = 32'h0040_0100;
   localparam logic [31:0] PJ = 32'h0040_0200;

   initial begin
      void'($urandom(32'd20240611));
      model_clear();
      repeat (2) @(posedge clk);
      do_reset();

      // R11 R3 R4: first branch after reset misses and allocates
      do_cycle(PA, 1'b1, 1'b0, '0, 16'hFFFC, 1'b0, '0, 1'b0, "R11 R3");
      // R4 R2 R7: hit on undecided entry, count 1 then 2
      do_cycle(PA, 1'b1, 1'b0, '0, 16'hFFFC, 1'b0, '0, 1'b0, "R4 R2 R7");
      do_cycle(PA, 1'b1, 1'b0, '0, 16'hFFFC, 1'b0, '0, 1'b0, "R7");
      // R10 R1 R6: resolve taken, negative offset target
      idle_resolve(PA, 1'b1, "R10");
      do_cycle(PA, 1'b1, 1'b0, '0, 16'hFFFC, 1'b0, '0, 1'b0, "R1 R6");
      check("R6", "branch target", nxt_pc, PA + 32'd4 - 32'd16);
      // R5: jump target with all-ones field, no upper bits merged
      do_cycle(PJ, 1'b0, 1'b1, 26'h3FF_FFFF, '0, 1'b0, '0, 1'b0, "R5");
      idle_resolve(PJ, 1'b1, "R5");
      do_cycle(PJ, 1'b0, 1'b1, 26'h3FF_FFFF, '0, 1'b0, '0, 1'b0, "R5");
      check("R5", "jump target", nxt_pc, 32'h0FFF_FFFC);
      // R10: resolve without a match is ignored
      idle_resolve(32'h0040_0300, 1'b1, "R10");
      do_cycle(32'h0040_0300, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, "R10 ignored");
      check("R10", "absent resolve hit", {31'd0, lk_hit}, 32'd0);
      // R10: resolve not-taken turns prediction off
      idle_resolve(PA, 1'b0, "R10");
      do_cycle(PA, 1'b1, 1'b0, '0, 16'hFFFC, 1'b0, '0, 1'b0, "R10 R2");
      check("R10", "not-taken pred", {31'd0, pred_taken}, 32'd0);
      // R8: repeated lookups of a held address keep one entry
      do_cycle(PJ, 1'b0, 1'b1, 26'h3FF_FFFF, '0, 1'b0, '0, 1'b0, "R8");

      // R9: fill, then round-robin replacement
      do_reset();
      for (int k = 0; k < 10; k++)
         do_cycle(32'h0010_0000 + 32'(k * 4), 1'b1, 1'b0, '0, 16'(k), 1'b0, '0, 1'b0, "R9 fill");
      do_cycle(32'h0010_000C, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, "R9 kept");
      check("R9", "entry 3 kept", {31'd0, lk_hit}, 32'd1);
      do_cycle(32'h0010_0000, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, "R9 evicted");
      check("R9", "entry 0 evicted", {31'd0, lk_hit}, 32'd0);
      // R10: allocation beats resolve on the replaced entry (pointer at slot 2)
      do_cycle(32'h0010_0100, 1'b1, 1'b0, '0, '0, 1'b1, 32'h0010_0008, 1'b1, "R10 R9 clash");
      do_cycle(32'h0010_0100, 1'b1, 1'b0, '0, '0, 1'b0, '0, 1'b0, "R10 alloc wins");
      check("R10", "clash pred", {31'd0, pred_taken}, 32'd0);

      // random mix against the reference model
      do_reset();
      for (int k = 0; k < 16; k++) begin
         pool_pc[k] = 32'h0080_0000 + 32'(k * 4);
         pool_br[k] = ($urandom % 3) == 0;
         pool_jp[k] = ($urandom % 4) == 0;
         pool_jf[k] = 26'($urandom);
         pool_im[k] = 16'($urandom);
      end
      for (int c = 0; c < 4000; c++) begin
         int a; int r;
         a = $urandom % 16;
         r = $urandom % 16;
         if (c == 2000) do_reset();
         do_cycle(pool_pc[a], pool_br[a], pool_jp[a], pool_jf[a], pool_im[a],
                  ($urandom % 3) == 0, pool_pc[r], 1'($urandom), "RND");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule